// File: doc/BRIEF.md
# Burst Address Counter with Load Strobe

This block generates the address that one port of a synchronous memory uses in each cycle. On every rising clock edge it samples four active-low controls and an external address, and from them it picks the address for the cycle now beginning. There are four choices: zero, the freshly sampled external address, the previous address plus one, or the previous address unchanged. A host can therefore start a burst at any location with one strobe, step through it with the count enable, pause it without losing its place, and return to location zero at any time.

The controls are registered at the edge. The chosen address is then formed from those registered values and presented combinationally, so the memory can use it within the same cycle. The counter keeps that address as its state for the following cycle. The load, step and clear actions do not depend on the chip-enable pair. That pair only decides whether the memory performs an access in the cycle, and the block reports this decision alongside the address. A clear cycle therefore also serves as an access to location zero, with no dead cycle.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `cur_addr` is 0 and `access_en` is 0.
- R2: When `clr_n` is low at a rising edge, `cur_addr` is 0 after that edge, whatever the levels of `load_n` and `step_n`.
- R3: When `clr_n` is high and `load_n` is low at a rising edge, `cur_addr` after that edge equals the `ext_addr` sampled at that edge, whatever the level of `step_n`.
- R4: When `clr_n` and `load_n` are high and `step_n` is low at a rising edge, `cur_addr` after that edge is the previous `cur_addr` plus one.
- R5: When `clr_n`, `load_n` and `step_n` are all high at a rising edge, `cur_addr` keeps its previous value, and `ext_addr` has no effect.
- R6: A step from the all-ones address (0x3FFF at the default width of 14) gives address 0.
- R7: R2 to R5 hold for every level of `cs0_n` and `cs1`, including when the memory is deselected.
- R8: After a rising edge, `access_en` is 1 exactly when `cs0_n` was low and `cs1` was high at that edge. This holds in clear cycles as well, so a clear and an access to address 0 happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock; all controls are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low block reset |
| ext_addr | input | AW (14) | External address loaded by the strobe |
| load_n | input | 1 | Active-low load strobe for the external address |
| step_n | input | 1 | Active-low count enable (advance by one) |
| clr_n | input | 1 | Active-low counter clear to address 0; highest priority |
| cs0_n | input | 1 | Active-low chip enable |
| cs1 | input | 1 | Active-high chip enable |
| cur_addr | output | AW (14) | Address used for the current cycle's access |
| access_en | output | 1 | High when the current cycle performs a memory access |

## Verification
Two things can coincide in one cycle: an address action (clear, load or step) and the memory access decided by the chip enables. Two address controls can also be asserted together, and then the priority decides. The bench sweeps every combination of the three address controls and both chip-enable levels, applied one after another so that each result depends on the address left by the previous cycle. A reference model computes the expected address by plain arithmetic and checks both outputs in every cycle. Clear cycles with the chip selected are judged on both outputs at once: the address must be zero and the access must be flagged.

// File: rtl/bac_pkg.sv
package bac_pkg;

  // Address source selected for a cycle, in rising priority order.
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_STEP = 2'd1,
    SRC_LOAD = 2'd2,
    SRC_ZERO = 2'd3
  } src_e;

  // Registered controls, converted to active-high.
  typedef struct packed {
    logic zero;
    logic load;
    logic step;
    logic sel;
  } ctl_t;

endpackage

// File: rtl/bac_in_reg.sv
module bac_in_reg
  import bac_pkg::*;
#(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ext_addr,
  input  logic          load_n,
  input  logic          step_n,
  input  logic          clr_n,
  input  logic          cs0_n,
  input  logic          cs1,
  output ctl_t          ctl_q,
  output logic [AW-1:0] addr_q
);

  ctl_t ctl_d;

  always_comb begin
    ctl_d.zero = ~clr_n;
    ctl_d.load = ~load_n;
    ctl_d.step = ~step_n;
    ctl_d.sel  = ~cs0_n & cs1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      addr_q <= '0;
    end else begin
      ctl_q  <= ctl_d;
      addr_q <= ext_addr;
    end
  end

endmodule

// File: rtl/bac_prio.sv
module bac_prio
  import bac_pkg::*;
(
  input  ctl_t ctl,
  output src_e src
);

  // Fixed priority: clear over load over step over hold.
  always_comb begin
    if (ctl.zero)      src = SRC_ZERO;
    else if (ctl.load) src = SRC_LOAD;
    else if (ctl.step) src = SRC_STEP;
    else               src = SRC_HOLD;
  end

endmodule

// File: rtl/bac_next.sv
module bac_next
  import bac_pkg::*;
#(
  parameter int AW = 14
) (
  input  src_e          src,
  input  logic [AW-1:0] ext_q,
  input  logic [AW-1:0] cnt_q,
  output logic [AW-1:0] nxt
);

  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] inc;

  // Modulo-2^AW increment: all-ones rolls over to zero.
  assign inc = cnt_q + ONE;

  always_comb begin
    unique case (src)
      SRC_ZERO: nxt = '0;
      SRC_LOAD: nxt = ext_q;
      SRC_STEP: nxt = inc;
      default:  nxt = cnt_q;
    endcase
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bac_pkg::*;
#(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ext_addr,
  input  logic          load_n,
  input  logic          step_n,
  input  logic          clr_n,
  input  logic          cs0_n,
  input  logic          cs1,
  output logic [AW-1:0] cur_addr,
  output logic          access_en
);

  localparam logic [AW-1:0] TOP_ADDR = {AW{1'b1}};

  ctl_t          ctl_q;
  logic [AW-1:0] ext_q;
  logic [AW-1:0] cnt_q;
  src_e          src;
  logic [AW-1:0] nxt;

  bac_in_reg #(.AW(AW)) u_in (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_addr (ext_addr),
    .load_n   (load_n),
    .step_n   (step_n),
    .clr_n    (clr_n),
    .cs0_n    (cs0_n),
    .cs1      (cs1),
    .ctl_q    (ctl_q),
    .addr_q   (ext_q)
  );

  bac_prio u_prio (
    .ctl (ctl_q),
    .src (src)
  );

  bac_next #(.AW(AW)) u_next (
    .src   (src),
    .ext_q (ext_q),
    .cnt_q (cnt_q),
    .nxt   (nxt)
  );

  // The counter holds the address used in this cycle for the next one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= nxt;
  end

  assign cur_addr  = nxt;
  assign access_en = ctl_q.sel;

  // R2 and R7: the clear wins over every other control and ignores the chip enables.
  a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> cur_addr == '0);

  // R3 and R7: the load strobe takes the external address.
  a_r3_load_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !load_n) |=> cur_addr == $past(ext_addr));

  // R4 and R7: the count enable advances by one.
  a_r4_step_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && !step_n) |=> cur_addr == AW'($past(cur_addr) + 1'b1));

  // R5: with no control asserted the address stays put.
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && step_n) |=> $stable(cur_addr));

  // R6: a step from the top address rolls over to zero.
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && !step_n && cur_addr == TOP_ADDR) |=> cur_addr == '0);

  // R8: the access flag follows the sampled chip enables.
  a_r8_access: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> access_en == $past(!cs0_n && cs1));

  // R1: held in reset, the outputs sit at zero.
  always_comb begin
    if (!rst_n) begin
      a_r1_reset_state: assert (cur_addr == '0 && access_en == 1'b0);
    end
  end

endmodule

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;

  localparam int AW = 14;
  localparam logic [AW-1:0] TOP = {AW{1'b1}};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic          load_n = 1'b1;
  logic          step_n = 1'b1;
  logic          clr_n = 1'b1;
  logic          cs0_n = 1'b1;
  logic          cs1 = 1'b0;
  logic [AW-1:0] cur_addr;
  logic          access_en;

  int errors = 0;
  int checks = 0;
  logic done = 1'b0;
  logic [AW-1:0] model = '0;
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  burst_addr_gen #(.AW(AW)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_addr  (ext_addr),
    .load_n    (load_n),
    .step_n    (step_n),
    .clr_n     (clr_n),
    .cs0_n     (cs0_n),
    .cs1       (cs1),
    .cur_addr  (cur_addr),
    .access_en (access_en)
  );

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Apply one cycle of stimulus at the falling edge, then check at the next falling edge.
  task automatic cycle(input logic c, input logic l, input logic s,
                       input logic e0, input logic e1, input logic [AW-1:0] a);
    string tag;
    logic  sel;
    clr_n = c; load_n = l; step_n = s; cs0_n = e0; cs1 = e1; ext_addr = a;
    sel = !e0 && e1;
    if (!c)      begin model = '0;                tag = "R2"; end
    else if (!l) begin model = a;                 tag = "R3"; end
    else if (!s) begin model = AW'(model + 1'b1); tag = "R4"; end
    else         tag = "R5";
    if (!sel) tag = {tag, "/R7"};
    @(posedge clk);
    @(negedge clk);
    check(tag, cur_addr, model);
    check(c ? "R8" : "R8 clear-with-access", {{(AW-1){1'b0}}, access_en}, {{(AW-1){1'b0}}, sel});
  endtask

  function automatic logic [AW-1:0] next_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[29:16];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state held
    check("R1 in reset", cur_addr, '0);
    check("R1 access in reset", {{(AW-1){1'b0}}, access_en}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", cur_addr, '0);
    check("R1 access after release", {{(AW-1){1'b0}}, access_en}, '0);

    // Start from a defined address with a clear.
    cycle(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, '0);

    // Sweep every control and enable combination, several passes, chained state.
    for (int p = 0; p < 6; p++) begin
      for (int k = 0; k < 32; k++) begin
        logic [4:0] v;
        v = k[4:0] ^ p[4:0];
        cycle(v[0], v[1], v[2], v[3], v[4], next_rand());
      end
    end

    // Long stepping and holding runs with random loads in between.
    for (int n = 0; n < 40; n++) begin
      cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, next_rand());
      for (int j = 0; j < 5; j++) cycle(1'b1, 1'b1, 1'b0, n[0], 1'b1, next_rand());
      for (int j = 0; j < 3; j++) cycle(1'b1, 1'b1, 1'b1, 1'b1, n[1], next_rand());
    end

    // R6: wrap from the top address, with and without the chip selected.
    cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, AW'(TOP - 1'b1));
    cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '0);
    check("R6 top reached", cur_addr, TOP);
    cycle(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, '0);
    check("R6 wrap to zero", cur_addr, '0);
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, TOP);
    cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 'h155);
    check("R6 wrap after load", cur_addr, '0);

    // R2: clear with load and step asserted together, chip selected.
    cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 'h2ABC);
    cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 'h1111);
    check("R2 clear over load and step", cur_addr, '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule